// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block keeps the privileged processor state that changes when control passes into a trap handler and back. It holds a mode word, a trap base register and the program counter pair. The mode word has a supervisor flag, a saved-supervisor flag, a trap-enable flag, a window pointer and an interrupt level. A trap request carries an 8-bit type. When traps are enabled, a trap turns traps off, saves the current mode, enters supervisor mode and steps the window pointer back by one. It hands the old PC and nPC to the register file through two save strobes and jumps to a vector slot built from the base address and the type. A return request reverses this with a delayed transfer: the window pointer steps forward, the old nPC becomes the PC, the target address becomes the nPC, the saved mode comes back and traps are enabled again.

A trap that arrives while traps are disabled does not vector. It stops the machine in an error state that only a reset request clears. Writes to the mode word and the base register are privileged. When one is attempted in user mode, the write is discarded and a privileged-instruction trap is raised in its place. Instruction decode, the register file and memory sit outside the block.

Top module: `trap_seq`

## Requirements
- R1: After rst_n is low or reset_req is high at a clock edge, pc=0, npc=4, error_mode=0, state_rd=0x001 (supervisor=1, all other fields 0) and base_rd=0. reset_req overrides every other request in the same cycle.
- R2: A trap taken with trap-enable=1 leaves, at the next edge, trap-enable=0, saved-supervisor equal to the old supervisor flag, and supervisor=1. state_rd layout: bit 0 supervisor, bit 1 saved-supervisor, bit 2 trap-enable, bits 7:3 window pointer, bits 11:8 interrupt level, all other bits 0.
- R3: Trap entry decrements the window pointer modulo NWIN (0 wraps to NWIN-1). No overflow check is made. The pointer always stays below NWIN.
- R4: In the cycle after a trap entry, save_l1_we and save_l2_we are 1, and save_l1_pc and save_l2_npc hold the pc and npc from before the trap. In every other cycle both strobes are 0.
- R5: After entry, base_rd bits 11:4 hold the trap type, bits 3:0 are 0 and bits 31:12 hold the base address. pc equals base_rd and npc equals base_rd+4.
- R6: A return request decrements nothing. It increments the window pointer modulo NWIN, loads pc with the old npc and npc with ret_addr, copies saved-supervisor into supervisor and sets trap-enable=1. Priority is reset, then trap, then return, then register writes.
- R7: A trap with trap-enable=0 sets error_mode=1 and leaves pc, npc, state_rd and base_rd unchanged. While error_mode=1, every request except reset_req is ignored.
- R8: wr_state in supervisor mode loads the mode word from wr_data in the state_rd layout. If wr_data bits 7:3 are not below NWIN, the window pointer keeps its old value.
- R9: wr_base in supervisor mode loads the base address from wr_data bits 31:12. The trap-type field is left unchanged.
- R10: wr_state or wr_base in user mode is discarded and raises a trap of type 0x03. If trap_req is high in the same cycle, its own type is used instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap request |
| trap_type | input | 8 | Type of the requested trap |
| reset_req | input | 1 | Reset trap request |
| ret_req | input | 1 | Return-from-trap request |
| ret_addr | input | XLEN | Return target address |
| wr_state | input | 1 | Privileged write strobe for the mode word |
| wr_base | input | 1 | Privileged write strobe for the trap base register |
| wr_data | input | XLEN | Write data for both registers |
| pc | output | XLEN | Program counter |
| npc | output | XLEN | Next program counter |
| state_rd | output | XLEN | Mode word |
| base_rd | output | XLEN | Trap base register |
| save_l1_we | output | 1 | Strobe to store old PC into local register 1 |
| save_l1_pc | output | XLEN | Old PC to be stored |
| save_l2_we | output | 1 | Strobe to store old nPC into local register 2 |
| save_l2_npc | output | XLEN | Old nPC to be stored |
| error_mode | output | 1 | Machine halted by a trap taken while traps were disabled |

## Verification
On every cycle, the assertions check the mode changes on entry and on return and the modulo window step. They also check that the save strobes carry the pre-trap counters, that the vector sits in a 16-byte slot with npc four bytes ahead, and that error mode and reset behave as required. Other behaviours show only in the bench's ordered scenarios against its own model. These are the wrap of the window pointer at both ends, the priority among requests that arrive in the same cycle, the privileged-trap type when a user write meets an external trap, and the rejection of an out-of-range window pointer on a write.

// File: rtl/trap_seq.sv
module trap_seq #(
  parameter int          NWIN    = 8,
  parameter int          XLEN    = 32,
  parameter logic [7:0]  PRIV_TT = 8'h03
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_req,
  input  logic [7:0]      trap_type,
  input  logic            reset_req,
  input  logic            ret_req,
  input  logic [XLEN-1:0] ret_addr,
  input  logic            wr_state,
  input  logic            wr_base,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] npc,
  output logic [XLEN-1:0] state_rd,
  output logic [XLEN-1:0] base_rd,
  output logic            save_l1_we,
  output logic [XLEN-1:0] save_l1_pc,
  output logic            save_l2_we,
  output logic [XLEN-1:0] save_l2_npc,
  output logic            error_mode
);
  localparam int            WW    = 5;
  localparam int            TBAW  = XLEN - 12;
  localparam logic [WW-1:0] WLAST = WW'(NWIN - 1);

  logic            sup, psup, ten, err_q, sv_we;
  logic [WW-1:0]   cwp;
  logic [3:0]      pil;
  logic [TBAW-1:0] tba;
  logic [7:0]      tt;
  logic [XLEN-1:0] pc_q, npc_q, sv_pc, sv_npc;

  logic            priv_fault, take, live, do_entry, do_fatal, do_ret, do_wr;
  logic [7:0]      ttype;
  logic [WW-1:0]   cwp_dn, cwp_up;
  logic [XLEN-1:0] vec;

  assign priv_fault = (wr_state | wr_base) & ~sup;
  assign take       = trap_req | priv_fault;
  assign ttype      = trap_req ? trap_type : PRIV_TT;
  assign live       = ~reset_req & ~err_q;
  assign do_entry   = live & take & ten;
  assign do_fatal   = live & take & ~ten;
  assign do_ret     = live & ~take & ret_req;
  assign do_wr      = live & ~take & ~ret_req;
  assign cwp_dn     = (cwp == '0) ? WLAST : cwp - 1'b1;
  assign cwp_up     = (cwp == WLAST) ? '0 : cwp + 1'b1;
  assign vec        = {tba, ttype, 4'b0000};

  always_ff @(posedge clk) begin
    if (!rst_n || reset_req) begin
      sup    <= 1'b1;
      psup   <= 1'b0;
      ten    <= 1'b0;
      cwp    <= '0;
      pil    <= '0;
      tba    <= '0;
      tt     <= '0;
      pc_q   <= '0;
      npc_q  <= XLEN'(4);
      err_q  <= 1'b0;
      sv_we  <= 1'b0;
      sv_pc  <= '0;
      sv_npc <= '0;
    end else begin
      sv_we <= 1'b0;
      if (do_entry) begin
        ten    <= 1'b0;
        psup   <= sup;
        sup    <= 1'b1;
        cwp    <= cwp_dn;
        sv_we  <= 1'b1;
        sv_pc  <= pc_q;
        sv_npc <= npc_q;
        tt     <= ttype;
        pc_q   <= vec;
        npc_q  <= vec + XLEN'(4);
      end else if (do_fatal) begin
        err_q <= 1'b1;
      end else if (do_ret) begin
        cwp   <= cwp_up;
        pc_q  <= npc_q;
        npc_q <= ret_addr;
        sup   <= psup;
        ten   <= 1'b1;
      end else if (do_wr) begin
        if (wr_state) begin
          sup  <= wr_data[0];
          psup <= wr_data[1];
          ten  <= wr_data[2];
          pil  <= wr_data[11:8];
          if (wr_data[7:3] <= WLAST) cwp <= wr_data[7:3];
        end
        if (wr_base) tba <= wr_data[XLEN-1:12];
      end
    end
  end

  assign pc          = pc_q;
  assign npc         = npc_q;
  assign state_rd    = {{(XLEN-12){1'b0}}, pil, cwp, ten, psup, sup};
  assign base_rd     = {tba, tt, 4'b0000};
  assign save_l1_we  = sv_we;
  assign save_l2_we  = sv_we;
  assign save_l1_pc  = sv_pc;
  assign save_l2_npc = sv_npc;
  assign error_mode  = err_q;

  a_r1_reset: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (pc_q == '0 && npc_q == XLEN'(4) && !error_mode && sup && !ten));

  a_r2_entry_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !reset_req && !error_mode && ten) |=> (sup && !ten && psup == $past(sup)));

  a_r3_window_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !reset_req && !error_mode && ten) |=>
      (cwp == (($past(cwp) == '0) ? WLAST : $past(cwp) - 1'b1)));

  a_r3_window_range: assert property (@(posedge clk) disable iff (!rst_n) cwp <= WLAST);

  a_r4_save: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !reset_req && !error_mode && ten) |=>
      (save_l1_we && save_l2_we && save_l1_pc == $past(pc_q) && save_l2_npc == $past(npc_q)));

  a_r5_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !reset_req && !error_mode && ten) |=>
      (pc_q[3:0] == 4'b0000 && pc_q == base_rd && npc_q == pc_q + XLEN'(4)));

  a_r6_return: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !trap_req && !wr_state && !wr_base && !reset_req && !error_mode) |=>
      (ten && sup == $past(psup) && pc_q == $past(npc_q) && npc_q == $past(ret_addr)));

  a_r7_fatal: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !reset_req && !error_mode && !ten) |=>
      (error_mode && $stable(pc_q) && $stable(npc_q) && $stable(state_rd)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (error_mode && !reset_req) |=> (error_mode && $stable(pc_q) && $stable(state_rd) && !save_l1_we));

  a_r10_priv_base: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base && !sup && !reset_req && !error_mode) |=> (tba == $past(tba)));
endmodule

// File: tb/tb_trap_seq.sv
module tb_trap_seq;
  localparam int NW = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        trap_req = 0, reset_req = 0, ret_req = 0, wr_state = 0, wr_base = 0;
  logic [7:0]  trap_type = '0;
  logic [31:0] ret_addr = '0, wr_data = '0;
  logic [31:0] pc, npc, state_rd, base_rd, save_l1_pc, save_l2_npc;
  logic        save_l1_we, save_l2_we, error_mode;

  trap_seq #(.NWIN(NW)) dut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
    .reset_req(reset_req), .ret_req(ret_req), .ret_addr(ret_addr),
    .wr_state(wr_state), .wr_base(wr_base), .wr_data(wr_data),
    .pc(pc), .npc(npc), .state_rd(state_rd), .base_rd(base_rd),
    .save_l1_we(save_l1_we), .save_l1_pc(save_l1_pc),
    .save_l2_we(save_l2_we), .save_l2_npc(save_l2_npc), .error_mode(error_mode));

  always #2 clk = ~clk;

  typedef struct {
    logic [31:0] pc, npc, st, bs, spc, snpc;
    logic        err, swe;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   nrun = 0, nfail = 0;
  bit   done = 0;

  logic       m_sup, m_ps, m_et, m_err;
  logic [4:0] m_cwp;
  logic [3:0] m_pil;
  logic [19:0] m_tba;
  logic [7:0]  m_tt;
  logic [31:0] m_pc, m_npc, m_spc, m_snpc;

  task automatic m_reset();
    m_sup = 1; m_ps = 0; m_et = 0; m_err = 0; m_cwp = 0; m_pil = 0;
    m_tba = 0; m_tt = 0; m_pc = 0; m_npc = 4; m_spc = 0; m_snpc = 0;
  endtask

  task automatic cyc(input logic tr, input logic [7:0] ty, input logic rr, input logic rt,
                     input logic [31:0] ra, input logic ws, input logic wb,
                     input logic [31:0] wd, input string tag);
    exp_t e;
    logic swe = 0;
    @(negedge clk);
    trap_req = tr; trap_type = ty; reset_req = rr; ret_req = rt; ret_addr = ra;
    wr_state = ws; wr_base = wb; wr_data = wd;
    if (rr) m_reset();
    else if (!m_err) begin
      logic pf, tk;
      logic [7:0] tp;
      pf = (ws | wb) & ~m_sup;
      tk = tr | pf;
      tp = tr ? ty : 8'h03;
      if (tk && m_et) begin
        m_et = 0; m_ps = m_sup; m_sup = 1;
        m_cwp = (m_cwp == 0) ? 5'(NW - 1) : m_cwp - 1;
        swe = 1; m_spc = m_pc; m_snpc = m_npc;
        m_tt = tp; m_pc = {m_tba, tp, 4'h0}; m_npc = m_pc + 4;
      end else if (tk) begin
        m_err = 1;
      end else if (rt) begin
        m_cwp = (m_cwp == 5'(NW - 1)) ? 5'd0 : m_cwp + 1;
        m_pc = m_npc; m_npc = ra; m_sup = m_ps; m_et = 1;
      end else begin
        if (ws) begin
          m_sup = wd[0]; m_ps = wd[1]; m_et = wd[2]; m_pil = wd[11:8];
          if (wd[7:3] < NW) m_cwp = wd[7:3];
        end
        if (wb) m_tba = wd[31:12];
      end
    end
    e.pc = m_pc; e.npc = m_npc;
    e.st = {20'h0, m_pil, m_cwp, m_et, m_ps, m_sup};
    e.bs = {m_tba, m_tt, 4'h0};
    e.err = m_err; e.swe = swe; e.spc = m_spc; e.snpc = m_snpc; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      nrun++;
      if (pc !== e.pc || npc !== e.npc || state_rd !== e.st || base_rd !== e.bs ||
          error_mode !== e.err || save_l1_we !== e.swe || save_l2_we !== e.swe ||
          (e.swe && (save_l1_pc !== e.spc || save_l2_npc !== e.snpc))) begin
        nfail++;
        $display("FAIL %s: pc=%h npc=%h st=%h bs=%h err=%b swe=%b spc=%h snpc=%h | exp pc=%h npc=%h st=%h bs=%h err=%b swe=%b spc=%h snpc=%h",
          e.tag, pc, npc, state_rd, base_rd, error_mode, save_l1_we, save_l1_pc, save_l2_npc,
          e.pc, e.npc, e.st, e.bs, e.err, e.swe, e.spc, e.snpc);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    nrun++;
    if (pc !== 0 || npc !== 4 || state_rd !== 32'h1 || base_rd !== 0 || error_mode !== 0 || save_l1_we !== 0) begin
      nfail++;
      $display("FAIL R1 reset: pc=%h npc=%h st=%h bs=%h err=%b exp pc=0 npc=4 st=1 bs=0 err=0",
               pc, npc, state_rd, base_rd, error_mode);
    end
    rst_n = 1;
    cyc(0, 0, 0, 0, 0, 1, 0, 32'h0000_0515, "R8 supervisor state write");
    cyc(0, 0, 0, 0, 0, 0, 1, 32'hABCD_E000, "R9 base write");
    cyc(1, 8'h11, 0, 0, 0, 0, 0, 0, "R2 R3 R4 R5 trap entry");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R4 strobe drops");
    cyc(0, 0, 0, 1, 32'h0000_1000, 0, 0, 0, "R6 return");
    cyc(0, 0, 0, 0, 0, 1, 0, 32'h0000_0004, "R8 enter user mode");
    cyc(0, 0, 0, 0, 0, 0, 1, 32'h1234_5000, "R10 R3 user base write traps, window wraps");
    cyc(0, 0, 0, 1, 32'h0000_2000, 0, 0, 0, "R6 return wraps window");
    cyc(1, 8'h22, 0, 1, 32'h0000_3000, 0, 0, 0, "R6 trap beats return");
    cyc(1, 8'h33, 0, 0, 0, 0, 0, 0, "R7 trap with traps disabled");
    cyc(0, 0, 0, 1, 32'h0000_4000, 0, 0, 0, "R7 return ignored in error");
    cyc(0, 0, 0, 0, 0, 1, 0, 32'h0000_0515, "R7 write ignored in error");
    cyc(1, 8'h44, 1, 0, 0, 0, 0, 0, "R1 reset request beats trap");
    cyc(0, 0, 0, 0, 0, 1, 0, 32'h0000_00FD, "R8 out-of-range window ignored");
    cyc(0, 0, 0, 0, 0, 1, 0, 32'h0000_0004, "R8 user mode again");
    cyc(1, 8'h80, 0, 0, 0, 0, 1, 32'hFFFF_F000, "R10 external type wins over privileged");
    cyc(0, 0, 0, 1, 32'h0000_5000, 0, 0, 0, "R6 back to user");
    cyc(0, 0, 0, 0, 0, 1, 0, 32'h0000_0FFF, "R10 user state write traps");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R4 idle");
    done = 1;
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule